// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block is the tag directory of a data cache that exists only for timing and statistics. It stores no data. A client presents load, store or swap requests with a 32-bit byte address. The directory looks the line up in every way of one set and answers one cycle later. The answer carries a hit flag, a miss-penalty cycle count and a way number. The way number is the matching way on a hit, or the way that was refilled on a load miss.

Only load misses allocate. A store miss reports its penalty and leaves the directory as it was. A swap is treated as a load followed by a store to the same line.

Victims come from one of two sources, fixed while reset is held. The first is a round-robin pointer kept for each set. The second is a single pointer shared by all sets that moves one step per refill and one extra step on every thirteenth refill. Four saturating counters record load hits, load misses, store hits and store misses. With the default geometry (16 KiB, 4 ways, 32-byte lines) there are 128 sets.

Top module: `cache_tag_dir`

## Requirements
- R1: While reset is held, `rspValid` is 0 and all four counters are 0. From the first clock after reset is released, `reqReady` is 1. Every tag entry is loaded with all ones (invalid).
- R2: The line address is the byte address shifted right by 5 bits. The set is bits [11:5] of the byte address. A hit needs the complete line address to equal a stored entry, so bytes within one line share an entry, and a line with the same set index but a different line address misses.
- R3: A load miss writes the line address into the victim way. It responds with `rspHit`=0, `rspPenalty`=30 and `rspWay`=victim.
- R4: A store miss responds with `rspHit`=0, `rspPenalty`=5 and `rspWay`=0, and allocates nothing, so a later load of that line still misses.
- R5: Any hit responds with `rspHit`=1, `rspPenalty`=0 and `rspWay` = the lowest matching way.
- R6: With `policySel`=0 at reset, every set has its own victim pointer. Each pointer starts at way 0, moves up by one after each refill in that set, and wraps from 3 to 0.
- R7: With `policySel`=1 at reset, one pointer shared by all sets gives the victim. It moves up by one (wrapping) after each refill. It moves one extra way on every 13th refill, after which the refill tally starts again.
- R8: `policySel` is read only while reset is held. Changing it afterwards does not change the policy in use.
- R9: `reqOp` encoding: 00 = load, 01 = store, 1x = swap. A swap updates the load counters and the victim exactly as a load would. It also counts one store hit. Its response equals that of the load alone.
- R10: Each counter increases by exactly one per counted event and holds at its all-ones value instead of wrapping.
- R11: A request accepted at a clock edge (`reqValid` and `reqReady` both 1) gives `rspValid`=1 after that same edge, for exactly one cycle. Accepted requests may follow one another every cycle, and each one sees the updates made by the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| policySel | input | 1 | Victim policy, read during reset: 0 per-set round-robin, 1 shared pointer |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Directory can accept a request |
| reqOp | input | 2 | 00 load, 01 store, 1x swap |
| reqAddr | input | 32 | Byte address |
| rspValid | output | 1 | Response for the request accepted at the previous edge |
| rspHit | output | 1 | Lookup hit |
| rspWay | output | 2 | Matching way, refilled way, or 0 on a store miss |
| rspPenalty | output | 8 | Miss penalty in cycles |
| ldHitCnt | output | CNT_W | Load hit count |
| ldMissCnt | output | CNT_W | Load miss count |
| stHitCnt | output | CNT_W | Store hit count |
| stMissCnt | output | CNT_W | Store miss count |

## Verification
The properties assume that reset is held for at least two clocks, so that every counter and response register has been cleared before any past value is used. They also assume that `reqOp` and `reqAddr` are stable at the edge where a request is accepted. The bench holds reset for three clocks. It changes inputs only on falling edges, so every request is fully set up before the rising edge that accepts it. No address in the stimulus has an all-ones line address, which means an invalid entry can never match a real request.

// File: rtl/ctd_pkg.sv
package ctd_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_SWAP  = 2'b10,
    OP_SWAP2 = 2'b11
  } ctdOp_e;

  // index of each statistic counter
  localparam int CNT_LD_HIT  = 0;
  localparam int CNT_LD_MISS = 1;
  localparam int CNT_ST_HIT  = 2;
  localparam int CNT_ST_MISS = 3;
  localparam int NUM_CNT     = 4;

  typedef struct packed {
    logic       accept;   // request taken this edge
    logic       ldPart;   // request contains a load
    logic       fill;     // load part missed: refill victim
    logic [3:0] cntInc;   // counter increment strobes
  } ctdStrobe_t;

endpackage

// File: rtl/ctd_ctrl.sv
module ctd_ctrl
  import ctd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       policySel,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       hit,
  output logic       reqReady,
  output logic       policyRnd,
  output ctdStrobe_t strobe
);

  logic readyQ;
  logic policyQ;
  logic ldPart;
  logic stPart;
  logic accept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ  <= 1'b0;
      policyQ <= policySel;
    end else begin
      readyQ  <= 1'b1;
    end
  end

  assign reqReady  = readyQ;
  assign policyRnd = policyQ;
  assign accept    = reqValid && readyQ;
  assign ldPart    = (reqOp != OP_STORE);
  assign stPart    = (reqOp != OP_LOAD);

  always_comb begin
    strobe        = '0;
    strobe.accept = accept;
    strobe.ldPart = ldPart;
    strobe.fill   = accept && ldPart && !hit;
    strobe.cntInc[CNT_LD_HIT]  = accept && ldPart && hit;
    strobe.cntInc[CNT_LD_MISS] = accept && ldPart && !hit;
    // the store half of a swap always finds the line its load just placed
    strobe.cntInc[CNT_ST_HIT]  = accept && stPart && (hit || ldPart);
    strobe.cntInc[CNT_ST_MISS] = accept && stPart && !ldPart && !hit;
  end

endmodule

// File: rtl/ctd_datapath.sv
module ctd_datapath
  import ctd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_BYTES = 16384,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 32,
  parameter int CNT_W      = 64,
  parameter int PEN_W      = 8,
  parameter int LD_PEN     = 30,
  parameter int ST_PEN     = 5,
  parameter int RND_PERIOD = 13,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int WAY_W     = $clog2(WAYS),
  localparam int SETS      = SIZE_BYTES / (LINE_BYTES * WAYS),
  localparam int SET_W     = $clog2(SETS),
  localparam int TAG_W     = ADDR_W - OFF_W,
  localparam int RCNT_W    = $clog2(RND_PERIOD)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic                          policyRnd,
  input  ctdStrobe_t                    strobe,
  output logic                          hit,
  output logic                          rspValid,
  output logic                          rspHit,
  output logic [WAY_W-1:0]              rspWay,
  output logic [PEN_W-1:0]              rspPenalty,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cnt
);

  logic [TAG_W-1:0]  tagMem [SETS][WAYS];
  logic [WAY_W-1:0]  rrPtr  [SETS];
  logic [WAY_W-1:0]  rndPtr;
  logic [RCNT_W-1:0] rndCnt;

  logic [TAG_W-1:0]  lineAddr;
  logic [SET_W-1:0]  setIdx;
  logic [WAYS-1:0]   wayMatch;
  logic [WAY_W-1:0]  hitWay;
  logic [WAY_W-1:0]  victimWay;

  assign lineAddr = reqAddr[ADDR_W-1:OFF_W];
  assign setIdx   = lineAddr[SET_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign wayMatch[w] = (tagMem[setIdx][w] == lineAddr);
  end

  assign hit = |wayMatch;

  always_comb begin
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (wayMatch[w]) hitWay = WAY_W'(w);
    end
  end

  assign victimWay = policyRnd ? rndPtr : rrPtr[setIdx];

  // tag store and per-set round-robin pointers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        rrPtr[s] <= '0;
        for (int w = 0; w < WAYS; w++) tagMem[s][w] <= '1;
      end
    end else if (strobe.fill) begin
      tagMem[setIdx][victimWay] <= lineAddr;
      if (!policyRnd) rrPtr[setIdx] <= rrPtr[setIdx] + 1'b1;
    end
  end

  // shared pointer with an extra step every RND_PERIOD refills
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rndPtr <= '0;
      rndCnt <= '0;
    end else if (strobe.fill && policyRnd) begin
      if (rndCnt == RCNT_W'(RND_PERIOD - 1)) begin
        rndCnt <= '0;
        rndPtr <= rndPtr + WAY_W'(2);
      end else begin
        rndCnt <= rndCnt + 1'b1;
        rndPtr <= rndPtr + 1'b1;
      end
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspHit     <= 1'b0;
      rspWay     <= '0;
      rspPenalty <= '0;
    end else begin
      rspValid <= strobe.accept;
      if (strobe.accept) begin
        rspHit <= hit;
        if (hit) begin
          rspWay     <= hitWay;
          rspPenalty <= '0;
        end else if (strobe.ldPart) begin
          rspWay     <= victimWay;
          rspPenalty <= PEN_W'(LD_PEN);
        end else begin
          rspWay     <= '0;
          rspPenalty <= PEN_W'(ST_PEN);
        end
      end
    end
  end

  // saturating statistics counters
  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN) cnt[c] <= '0;
      else if (strobe.cntInc[c] && (cnt[c] != '1)) cnt[c] <= cnt[c] + 1'b1;
    end
  end

endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
  import ctd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_BYTES = 16384,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 32,
  parameter int CNT_W      = 64,
  parameter int PEN_W      = 8,
  parameter int LD_PEN     = 30,
  parameter int ST_PEN     = 5,
  parameter int RND_PERIOD = 13,
  localparam int WAY_W     = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              policySel,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              rspHit,
  output logic [WAY_W-1:0]  rspWay,
  output logic [PEN_W-1:0]  rspPenalty,
  output logic [CNT_W-1:0]  ldHitCnt,
  output logic [CNT_W-1:0]  ldMissCnt,
  output logic [CNT_W-1:0]  stHitCnt,
  output logic [CNT_W-1:0]  stMissCnt
);

  ctdStrobe_t                    strobe;
  logic                          hit;
  logic                          policyRnd;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;

  ctd_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .policySel (policySel),
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .hit       (hit),
    .reqReady  (reqReady),
    .policyRnd (policyRnd),
    .strobe    (strobe)
  );

  ctd_datapath #(
    .ADDR_W     (ADDR_W),
    .SIZE_BYTES (SIZE_BYTES),
    .WAYS       (WAYS),
    .LINE_BYTES (LINE_BYTES),
    .CNT_W      (CNT_W),
    .PEN_W      (PEN_W),
    .LD_PEN     (LD_PEN),
    .ST_PEN     (ST_PEN),
    .RND_PERIOD (RND_PERIOD)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqAddr    (reqAddr),
    .policyRnd  (policyRnd),
    .strobe     (strobe),
    .hit        (hit),
    .rspValid   (rspValid),
    .rspHit     (rspHit),
    .rspWay     (rspWay),
    .rspPenalty (rspPenalty),
    .cnt        (cnt)
  );

  assign ldHitCnt  = cnt[CNT_LD_HIT];
  assign ldMissCnt = cnt[CNT_LD_MISS];
  assign stHitCnt  = cnt[CNT_ST_HIT];
  assign stMissCnt = cnt[CNT_ST_MISS];

endmodule

// File: rtl/cache_tag_dir_chk.sv
module cache_tag_dir_chk #(
  parameter int CNT_W  = 64,
  parameter int PEN_W  = 8,
  parameter int LD_PEN = 30,
  parameter int ST_PEN = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [1:0]       reqOp,
  input logic             rspValid,
  input logic             rspHit,
  input logic [PEN_W-1:0] rspPenalty,
  input logic [CNT_W-1:0] ldHitCnt,
  input logic [CNT_W-1:0] ldMissCnt,
  input logic [CNT_W-1:0] stHitCnt,
  input logic [CNT_W-1:0] stMissCnt
);

  logic accept;
  assign accept = reqValid && reqReady;

  p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> reqReady);

  p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> rspValid);

  p_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> !rspValid);

  p_hit_no_penalty_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit) |-> (rspPenalty == '0));

  p_load_miss_penalty_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqOp != 2'b01) |=> (rspHit || rspPenalty == PEN_W'(LD_PEN)));

  p_store_miss_penalty_r4: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqOp == 2'b01) |=> (rspHit || rspPenalty == PEN_W'(ST_PEN)));

  p_swap_counts_store_hit_r9: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqOp[1]) |=> (stHitCnt != $past(stHitCnt) || stHitCnt == '1));

  p_counters_monotonic_r10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (ldHitCnt >= $past(ldHitCnt) && ldMissCnt >= $past(ldMissCnt) &&
              stHitCnt >= $past(stHitCnt) && stMissCnt >= $past(stMissCnt)));

  p_idle_counters_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> ($stable(ldHitCnt) && $stable(ldMissCnt) &&
                 $stable(stHitCnt) && $stable(stMissCnt)));

endmodule

bind cache_tag_dir cache_tag_dir_chk #(
  .CNT_W  (CNT_W),
  .PEN_W  (PEN_W),
  .LD_PEN (LD_PEN),
  .ST_PEN (ST_PEN)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqOp      (reqOp),
  .rspValid   (rspValid),
  .rspHit     (rspHit),
  .rspPenalty (rspPenalty),
  .ldHitCnt   (ldHitCnt),
  .ldMissCnt  (ldMissCnt),
  .stHitCnt   (stHitCnt),
  .stMissCnt  (stMissCnt)
);

// File: tb/cache_tag_dir_tb.sv
module cache_tag_dir_tb;

  localparam int CW   = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          policySel = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [1:0]    reqOp = 2'b00;
  logic [31:0]   reqAddr = '0;
  logic          rspValid;
  logic          rspHit;
  logic [1:0]    rspWay;
  logic [7:0]    rspPenalty;
  logic [CW-1:0] ldHitCnt, ldMissCnt, stHitCnt, stMissCnt;

  always #5 clk = ~clk;

  cache_tag_dir #(.CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .policySel(policySel),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspHit(rspHit), .rspWay(rspWay), .rspPenalty(rspPenalty),
    .ldHitCnt(ldHitCnt), .ldMissCnt(ldMissCnt), .stHitCnt(stHitCnt), .stMissCnt(stMissCnt)
  );

  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  // behavioural reference state
  logic [26:0] mTag [128][4];
  int  mRr [128];
  int  mRndPtr, mRndCnt;
  bit  mPol;
  int  mLdHit, mLdMiss, mStHit, mStMiss;
  bit  eHit;
  int  eWay, ePen;
  string tagTxt;
  int unsigned lcg = 32'h1234_5678;

  task automatic chk(string req, string what, longint act, longint exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(int v);
    return (v > CMAX) ? CMAX : v;
  endfunction

  function automatic int findWay(logic [26:0] line);
    int s = int'(line[6:0]);
    for (int w = 0; w < 4; w++) if (mTag[s][w] == line) return w;
    return -1;
  endfunction

  task automatic modelReset(bit pol);
    for (int s = 0; s < 128; s++) begin
      mRr[s] = 0;
      for (int w = 0; w < 4; w++) mTag[s][w] = '1;
    end
    mRndPtr = 0; mRndCnt = 0; mPol = pol;
    mLdHit = 0; mLdMiss = 0; mStHit = 0; mStMiss = 0;
  endtask

  task automatic modelReq(logic [1:0] op, logic [31:0] addr);
    logic [26:0] line = addr[31:5];
    int s = int'(line[6:0]);
    int w;
    bit ld = (op != 2'b01);
    bit st = (op != 2'b00);
    if (ld) begin
      w = findWay(line);
      if (w >= 0) begin
        mLdHit++; eHit = 1; eWay = w; ePen = 0; tagTxt = "R5";
      end else begin
        int v;
        mLdMiss++; eHit = 0; ePen = 30;
        if (mPol) begin
          v = mRndPtr;
          mRndPtr = (mRndPtr + 1) % 4;
          mRndCnt++;
          if (mRndCnt == 13) begin mRndCnt = 0; mRndPtr = (mRndPtr + 1) % 4; end
          tagTxt = "R3/R7";
        end else begin
          v = mRr[s];
          mRr[s] = (mRr[s] + 1) % 4;
          tagTxt = "R3/R6";
        end
        mTag[s][v] = line;
        eWay = v;
      end
    end
    if (st) begin
      w = findWay(line);
      if (w >= 0) mStHit++; else mStMiss++;
      if (!ld) begin
        eHit = (w >= 0);
        eWay = (w >= 0) ? w : 0;
        ePen = (w >= 0) ? 0 : 5;
        tagTxt = (w >= 0) ? "R5" : "R4";
      end else tagTxt = {tagTxt, "/R9"};
    end
  endtask

  task automatic chkCounters(string req);
    chk(req, "ldHitCnt",  ldHitCnt,  sat(mLdHit));
    chk(req, "ldMissCnt", ldMissCnt, sat(mLdMiss));
    chk(req, "stHitCnt",  stHitCnt,  sat(mStHit));
    chk(req, "stMissCnt", stMissCnt, sat(mStMiss));
  endtask

  task automatic doReq(logic [1:0] op, logic [31:0] addr, string phase);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = addr;
    modelReq(op, addr);
    @(posedge clk); #1;
    chk({phase, " R11"}, "rspValid", rspValid, 1);
    chk({phase, " ", tagTxt}, "rspHit", rspHit, eHit);
    chk({phase, " ", tagTxt}, "rspWay", rspWay, eWay);
    chk({phase, " ", tagTxt}, "rspPenalty", rspPenalty, ePen);
    chkCounters({phase, " R10"});
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
    @(posedge clk); #1;
    chk("R11", "rspValid idle", rspValid, 0);
    chkCounters("R10 idle");
  endtask

  task automatic doReset(bit pol);
    @(negedge clk);
    rstN = 1'b0; reqValid = 1'b0; policySel = pol;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "rspValid in reset", rspValid, 0);
    chk("R1", "ldHitCnt in reset", ldHitCnt, 0);
    chk("R1", "stMissCnt in reset", stMissCnt, 0);
    modelReset(pol);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1", "reqReady after reset", reqReady, 1);
  endtask

  function automatic logic [31:0] mk(int tagHi, int set, int off);
    return (32'(tagHi) << 12) | (32'(set) << 5) | 32'(off);
  endfunction

  task automatic randomOps(int n, string phase);
    for (int i = 0; i < n; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      doReq(2'((lcg >> 24) % 3), mk(int'((lcg >> 16) & 7), 20 + int'((lcg >> 8) & 3),
                                    int'(lcg & 31)), phase);
    end
  endtask

  initial begin
    // ---- round-robin phase ----
    doReset(1'b0);
    // R6: five lines into set 3 -> ways 0,1,2,3 then 0 again
    for (int k = 1; k <= 5; k++) doReq(2'b00, mk(k, 3, 0), "R6");
    doReq(2'b00, mk(1, 3, 4), "R6 evicted line");          // line 1 was evicted
    doReq(2'b00, mk(7, 4, 0), "R6 other set starts at 0");
    // R2: same line, different byte offset hits; same set other line misses
    doReq(2'b00, mk(7, 4, 31), "R2");
    doReq(2'b00, mk(8, 4, 31), "R2");
    // R4: store miss then load of same line still misses
    doReq(2'b01, mk(9, 5, 8), "R4");
    doReq(2'b00, mk(9, 5, 8), "R4");
    doReq(2'b01, mk(9, 5, 12), "R5 store hit");
    // R9: swap on fresh line, then again
    doReq(2'b10, mk(3, 6, 0), "R9");
    doReq(2'b11, mk(3, 6, 16), "R9");
    idle();
    // R8: policy input changes after reset, round-robin must remain
    policySel = 1'b1;
    for (int k = 1; k <= 6; k++) doReq(2'b00, mk(k + 20, 7, 0), "R8");
    randomOps(150, "R10 mix");
    idle();
    // ---- shared pointer phase ----
    doReset(1'b1);
    for (int k = 1; k <= 40; k++) doReq(2'b00, mk(k, 9 + (k % 3), 0), "R7");
    policySel = 1'b0;
    for (int k = 1; k <= 6; k++) doReq(2'b00, mk(k + 50, 30, 0), "R8");
    randomOps(150, "R7 mix");
    idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++; misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule